// File: doc/BRIEF.md
# EDO DRAM Data Output Controller

This block is the output side of an extended-data-out DRAM: it holds the output latch and decides when the data pins are driven. The four active-low strobes (row strobe, column strobe, output enable, write enable) are sampled on a system clock. The block finds their edges and works out the kind of memory cycle in progress from the order in which they move. It then opens or closes the internal I/O path, loads the output latch from the array's read data, and turns the tri-state enable on or off.

The block covers reads, extended-data-out page accesses, early writes, late writes, read-modify-write, RAS-only refresh, CAS-before-RAS refresh (including hidden refresh) and CAS-only cycles. When the row strobe rises while the output is driving and the column strobe is still low, the latched word keeps driving. This is the extended output that gives the device its name. A refresh started with the column strobe already low keeps whatever the output held before it.

The array presents read data continuously for the open row, so the read bus is a plain sampled input with no valid/ready handshake and no back-pressure. The latch takes the bus value on every clock in which the path is open for reading. Every strobe change shows at the outputs two clocks later: one capture stage, then the output registers.

Top module: `dram_dq_ctrl`

## Requirements
- R1: After reset, dq_oe is 0, path_open is 0 and dq_out is 0.
- R2: A falling ras_n with cas_n high opens a row. While the row is open, path_open is 1 exactly when cas_n is low. A row opened and closed without a cas_n fall (RAS-only refresh) never sets dq_oe.
- R3: In an open row, with cas_n low, we_n high and no early write pending, the latch loads rd_data on every clock. dq_oe is 1 when oe_n is also low, and dq_out then shows the loaded word.
- R4: oe_n high forces dq_oe to 0 but does not stop the latch from loading. Lowering oe_n again drives the word already loaded.
- R5: cas_n high forces dq_oe to 0, in every cycle type.
- R6: An early write is a cas_n fall sampled with we_n already low, including when both fall in the same sample. It keeps dq_oe at 0 for that column access and leaves the latch unchanged.
- R7: In a late write or read-modify-write, where we_n falls after cas_n, the outputs follow oe_n until we_n falls. Low we_n then forces dq_oe to 0 and freezes the latch.
- R8: If ras_n rises while dq_oe is 1 and cas_n is low, the latched word keeps driving. rd_data is ignored, oe_n still gates the drivers, and driving ends when cas_n goes high.
- R9: A ras_n fall with cas_n low in the preceding sample is a CAS-before-RAS refresh. For its whole length the latch does not change and dq_oe can only keep its prior value or drop. A hidden refresh that follows R8 resumes extended output when ras_n rises.
- R10: A cas_n fall while ras_n is high and no extended output is active leaves dq_oe and path_open at 0.
- R11: If ras_n and cas_n fall in the same sample, the cycle is a normal access, not a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_data | input | DATA_W | Word read from the array for the current column |
| dq_out | output | DATA_W | Output latch contents |
| dq_oe | output | 1 | Tri-state enable for the data pins |
| path_open | output | 1 | Internal I/O path open for the current column |

## Verification
Two functions can fall in the same sample: classifying a row strobe fall as access or refresh, and opening the column path. The bench forces this by dropping ras_n and cas_n in one step and expects a normal read that drives the current rd_data, not a refresh that holds the old latch. It also drops cas_n and we_n in one step, which must count as an early write with the drivers off and the latch unchanged. A near-exhaustive sweep over output-enable level, write timing and data pattern judges each step against values worked out from the requirements.

// File: rtl/dram_dq_pkg.sv
package dram_dq_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_ROW  = 2'd1,
    CYC_XOUT = 2'd2,
    CYC_REFR = 2'd3
  } cyc_e;

  typedef struct packed {
    logic ras;
    logic cas;
    logic oe;
    logic we;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler
  import dram_dq_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t raw,
  output strobe_t cur,
  output logic    ras_prev,
  output logic    cas_prev
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][STROBE_W-1:0] pipe;
  logic [1:0]                      prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign cur = strobe_t'(pipe[LAST]);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= {cur.ras, cur.cas};
  end

  assign ras_prev = prev_q[1];
  assign cas_prev = prev_q[0];

endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
  import dram_dq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ras_prev,
  input  logic cas_prev,
  input  logic drive_q,
  output cyc_e cyc_nx,
  output logic early_nx
);

  cyc_e cyc_q;
  logic early_q;
  logic ras_fall, ras_rise, cas_fall;
  logic keep_out;

  assign ras_fall = ras_prev & ~ras_n;
  assign ras_rise = ~ras_prev & ras_n;
  assign cas_fall = cas_prev & ~cas_n;
  assign keep_out = drive_q & ~cas_n;

  always_comb begin
    cyc_nx = cyc_q;
    unique case (cyc_q)
      CYC_IDLE: begin
        if (ras_fall) cyc_nx = cas_prev ? CYC_ROW : CYC_REFR;
      end
      CYC_ROW: begin
        if (ras_rise) cyc_nx = keep_out ? CYC_XOUT : CYC_IDLE;
      end
      CYC_XOUT: begin
        if (ras_fall)   cyc_nx = cas_prev ? CYC_ROW : CYC_REFR;
        else if (cas_n) cyc_nx = CYC_IDLE;
      end
      CYC_REFR: begin
        if (ras_rise) cyc_nx = keep_out ? CYC_XOUT : CYC_IDLE;
      end
      default: cyc_nx = CYC_IDLE;
    endcase
  end

  always_comb begin
    if (cyc_nx != CYC_ROW) early_nx = 1'b0;
    else if (cas_fall)     early_nx = ~we_n;
    else                   early_nx = early_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= CYC_IDLE;
      early_q <= 1'b0;
    end else begin
      cyc_q   <= cyc_nx;
      early_q <= early_nx;
    end
  end

endmodule

// File: rtl/dram_dq_latch.sv
module dram_dq_latch
  import dram_dq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc_nx,
  input  logic              early_nx,
  input  logic              cas_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] data_q,
  output logic              drive_q,
  output logic              path_q
);

  logic col_read;
  logic pin_ok;
  logic drive_nx, load, path_nx;

  assign col_read = ~cas_n & we_n;
  assign pin_ok   = col_read & ~oe_n;

  always_comb begin
    drive_nx = 1'b0;
    unique case (cyc_nx)
      CYC_ROW:  drive_nx = pin_ok & ~early_nx;
      CYC_XOUT: drive_nx = pin_ok;
      CYC_REFR: drive_nx = pin_ok & drive_q;
      default:  drive_nx = 1'b0;
    endcase
  end

  assign load    = (cyc_nx == CYC_ROW) & col_read & ~early_nx;
  assign path_nx = (cyc_nx == CYC_ROW) & ~cas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      drive_q <= 1'b0;
      path_q  <= 1'b0;
    end else begin
      if (load) data_q <= rd_data;
      drive_q <= drive_nx;
      path_q  <= path_nx;
    end
  end

endmodule

// File: rtl/dram_dq_ctrl.sv
module dram_dq_ctrl
  import dram_dq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              path_open
);

  strobe_t raw, cur;
  logic    ras_prev, cas_prev;
  cyc_e    cyc_nx;
  logic    early_nx;
  logic    drive_q;

  assign raw = '{ras: ras_n, cas: cas_n, oe: oe_n, we: we_n};

  dram_strobe_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (raw),
    .cur      (cur),
    .ras_prev (ras_prev),
    .cas_prev (cas_prev)
  );

  dram_cycle_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (cur.ras),
    .cas_n    (cur.cas),
    .we_n     (cur.we),
    .ras_prev (ras_prev),
    .cas_prev (cas_prev),
    .drive_q  (drive_q),
    .cyc_nx   (cyc_nx),
    .early_nx (early_nx)
  );

  dram_dq_latch #(.DATA_W(DATA_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_nx   (cyc_nx),
    .early_nx (early_nx),
    .cas_n    (cur.cas),
    .oe_n     (cur.oe),
    .we_n     (cur.we),
    .rd_data  (rd_data),
    .data_q   (dq_out),
    .drive_q  (drive_q),
    .path_q   (path_open)
  );

  assign dq_oe = drive_q;

endmodule

// File: rtl/dram_dq_ctrl_chk.sv
module dram_dq_ctrl_chk #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cas_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              path_open
);

  localparam int LAT = SYNC_STAGES + 1;

  // R5: column strobe high turns the drivers off
  p_cas_high_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cas_n, LAT) |-> !dq_oe);

  // R4: output enable high turns the drivers off
  p_oe_high_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n, LAT) |-> !dq_oe);

  // R7: write enable low turns the drivers off
  p_we_low_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_n, LAT) |-> !dq_oe);

  // R2: the path can only be open while the column strobe is low
  p_path_needs_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    path_open |-> !$past(cas_n, LAT));

  // R3: the latch moves only while the path is open
  p_latch_on_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dq_out) |-> path_open);

endmodule

bind dram_dq_ctrl dram_dq_ctrl_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cas_n     (cas_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .path_open (path_open)
);

// File: tb/tb_dram_dq_ctrl.sv
`timescale 1ns/1ps
module tb_dram_dq_ctrl;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ras_n = 1'b1, cas_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [W-1:0] rd_data = '0;
  logic [W-1:0] dq_out;
  logic         dq_oe, path_open;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] lat;

  always #4 clk = ~clk;

  dram_dq_ctrl #(.DATA_W(W), .SYNC_STAGES(1)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .we_n(we_n), .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe),
    .path_open(path_open)
  );

  task automatic drive(input logic r, input logic c, input logic o, input logic w);
    @(negedge clk);
    ras_n = r; cas_n = c; oe_n = o; we_n = w;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic e_oe, input logic [W-1:0] e_d, input logic e_path);
    checks++;
    if (dq_oe !== e_oe || dq_out !== e_d || path_open !== e_path) begin
      errors++;
      $display("FAIL %s: oe=%b data=%h path=%b expected oe=%b data=%h path=%b",
               req, dq_oe, dq_out, path_open, e_oe, e_d, e_path);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    lat = '0;
    chk("R1 reset", 1'b0, '0, 1'b0);

    // sweep: OE level x write timing (0 read, 1 early, 2 late) x data pattern
    for (int o = 0; o < 2; o++) begin
      for (int wm = 0; wm < 3; wm++) begin
        for (int p = 0; p < 4; p++) begin
          pat = W'(16'h5A3C + p * 16'h1357 + o * 16'h0F0F + wm * 16'h0101);
          rd_data = pat;
          drive(1'b0, 1'b1, o[0], (wm == 1) ? 1'b0 : 1'b1);
          chk("R2 row open, column closed", 1'b0, lat, 1'b0);
          drive(1'b0, 1'b0, o[0], (wm == 1) ? 1'b0 : 1'b1);
          if (wm != 1) lat = pat;
          if (wm == 1) chk("R6 early write high-Z", 1'b0, lat, 1'b1);
          else if (o == 0) chk("R3 read drives", 1'b1, lat, 1'b1);
          else chk("R4 oe high off but loaded", 1'b0, lat, 1'b1);
          if (wm == 2) begin
            drive(1'b0, 1'b0, o[0], 1'b0);
            rd_data = ~pat;
            settle();
            chk("R7 late write off, latch frozen", 1'b0, lat, 1'b1);
          end
          if (wm == 0 && o == 1) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1);
            chk("R4 oe low drives loaded word", 1'b1, lat, 1'b1);
          end
          drive(1'b0, 1'b1, 1'b1, 1'b1);
          chk("R5 cas high off", 1'b0, lat, 1'b0);
          drive(1'b1, 1'b1, 1'b1, 1'b1);
          chk("R2 row closed", 1'b0, lat, 1'b0);
        end
      end
    end

    // RAS-only refresh
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R2 ras-only refresh high-Z", 1'b0, lat, 1'b0);

    // extended output and hidden refresh
    rd_data = 16'hC0DE;
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    lat = 16'hC0DE;
    chk("R3 read", 1'b1, lat, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    rd_data = 16'h1111;
    settle();
    chk("R8 extended output after ras rise", 1'b1, lat, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R8 oe high gates extended output", 1'b0, lat, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R8 oe low resumes extended output", 1'b1, lat, 1'b0);
    rd_data = 16'h2222;
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 hidden refresh holds data", 1'b1, lat, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9 hidden refresh returns to extended output", 1'b1, lat, 1'b0);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 cas high ends extended output", 1'b0, lat, 1'b0);

    // CAS-only, then CAS-before-RAS from idle
    rd_data = 16'h3333;
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R10 cas-only no effect", 1'b0, lat, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 cbr refresh keeps latch", 1'b0, lat, 1'b0);
    rd_data = 16'h4444;
    settle();
    chk("R9 cbr ignores read data", 1'b0, lat, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9 after cbr", 1'b0, lat, 1'b0);

    // simultaneous RAS and CAS fall
    rd_data = 16'h5EED;
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    lat = 16'h5EED;
    chk("R11 same-sample fall is access", 1'b1, lat, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1);

    // simultaneous CAS and WE fall, then EDO page
    rd_data = 16'h7777;
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 same-sample cas/we fall is early write", 1'b0, lat, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    rd_data = 16'h8888;
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    lat = 16'h8888;
    chk("R3 page read after early write", 1'b1, lat, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    rd_data = 16'h9999;
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    lat = 16'h9999;
    chk("R3 second page column", 1'b1, lat, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R5 end of page", 1'b0, lat, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule